// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the bit-level half of an I2C master. A controller above it hands over one command at a time (bus recovery, START, STOP, byte write or byte read) and the engine produces the matching SCL/SDA waveforms on an open-drain bus. The engine never drives a line high. It only asserts an output enable that pulls the line low, and a released line is raised by the external pull-up.

Bit timing comes from a delay unit of `divider + 1` system clocks, captured when a command is accepted. Every step of a command lasts a whole number of units. When a command finishes, the engine raises a one-cycle `done` pulse. The received byte, or the acknowledge level sampled after a written byte, stays on the outputs until a later command replaces it. The SCL level at the end of a command is held, so the next command continues from it. The bus-recovery command clocks nine pulses with SDA released and then issues a STOP, which frees a slave left holding SDA in the middle of a byte.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `sclOe`=0, `sdaOe`=0, `cmdReady`=1, `done`=0, `rxData`=0 and `ackBit`=0.
- R2: A command is accepted only in a cycle where `cmdReady`, `cmdValid` are 1 and `cmdCode` is one of 0 recover, 1 START, 2 STOP, 3 write, 4 read. After acceptance `cmdReady` stays 0 until the command finishes. Requests made while busy, and codes 5 to 7, are ignored and produce no `done`.
- R3: One delay unit is `divider`+1 clocks, with `divider` captured at acceptance. `done` is a single-cycle pulse that comes N units after the accepting edge, where N is 3 for START, 4 for STOP, 37 for write, 29 for read and 41 for recover.
- R4: START releases SDA, then releases SCL, then pulls SDA low while SCL is high, one unit per step. It ends with SCL released and SDA driven low, and it creates exactly one start condition.
- R5: STOP drives SCL low, drives SDA low, releases SCL, then releases SDA while SCL is high, one unit per step. It ends with both lines released and creates exactly one stop condition.
- R6: Write sends `cmdData` MSB first. Each bit is SCL low for one unit, SDA set and held for one unit, then SCL high for two units. SDA never changes while SCL stays high during a write or read.
- R7: After the eight data bits, a write releases SDA for a ninth pulse and samples SDA at the end of its high phase. `ackBit` is set to that level (0 = acknowledged). A write leaves `rxData` unchanged.
- R8: Read releases SDA and clocks eight pulses. SDA is sampled one unit after each SCL rising edge and the bits are assembled MSB first. `rxData` changes only at the `done` of a read, and a read leaves `ackBit` unchanged.
- R9: After the eight read bits, the engine drives `cmdAckLevel` on SDA through a ninth pulse. A level of 0 pulls SDA low (ACK) and a level of 1 releases it (NACK).
- R10: Write and read end with SCL driven low. While the engine is idle and accepts nothing, `sclOe` and `sdaOe` do not change.
- R11: Recover releases both lines for one unit, then gives nine SCL pulses, each with two units low and two units high, with SDA released. It then performs the STOP sequence. Starting from an idle bus this gives ten SCL rising edges, one stop condition and no start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdCode | input | 3 | 0 recover, 1 START, 2 STOP, 3 write, 4 read |
| cmdData | input | 8 | Byte to write |
| cmdAckLevel | input | 1 | Acknowledge level to drive after a read (0 ACK, 1 NACK) |
| divider | input | DIV_W | Delay unit length minus one, in clocks |
| sdaIn | input | 1 | SDA line level, asynchronous |
| cmdReady | output | 1 | Engine idle and able to accept a command |
| done | output | 1 | One-cycle completion pulse |
| rxData | output | 8 | Byte from the last read |
| ackBit | output | 1 | SDA level sampled in the acknowledge slot of the last write |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Some properties are checked on every cycle: `done` lasts one cycle and coincides with idle, SDA stays put while SCL is high during byte transfers, both line enables stay frozen while the engine is idle, and `rxData`/`ackBit` change only as their own command allows. The bench checks the rest by running scenarios against a slave model on the wired-AND bus. That covers the bit order and values seen by the slave, the sampled acknowledge and received byte, the exact completion latency for each command, the start and stop conditions counted on the lines, the ten rising edges of recovery, and that illegal codes or requests made while busy are ignored.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CMD_RECOVER = 3'd0,
    CMD_START   = 3'd1,
    CMD_STOP    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_READ    = 3'd4
  } cmd_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_RINIT, ST_RLOW, ST_RHIGH,
    ST_SA, ST_SB, ST_SC,
    ST_PA, ST_PB, ST_PC, ST_PD,
    ST_BLOW, ST_BSET, ST_BHIGH,
    ST_DLOW, ST_DHIGH, ST_DHOLD,
    ST_ELOW
  } state_e;

  // One-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // capture command operands, restart unit timer
    logic sclLow;
    logic sclHigh;
    logic sdaLow;
    logic sdaHigh;
    logic sdaTx;      // drive current transmit MSB
    logic sdaAck;     // drive captured acknowledge level
    logic shiftTx;
    logic captureRx;
    logic captureAck;
    logic commitRx;
  } strobe_t;

endpackage

// File: rtl/i2c_bit_dp.sv
module i2c_bit_dp
  import i2c_bit_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdAckLevel,
  input  logic [DIV_W-1:0]  divider,
  input  logic              sdaIn,
  output logic              tick,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rxData,
  output logic              ackBit
);

  logic [DIV_W-1:0]  divReg, tickCnt;
  logic [BYTE_W-1:0] txShift, rxShift;
  logic              ackLvl;
  logic              sdaSync;

  assign tick = (tickCnt == '0);

  // Unit timer: counts down, reloads on expiry or on a new command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= '0;
      tickCnt <= '0;
    end else if (st.load) begin
      divReg  <= divider;
      tickCnt <= divider;
    end else if (tick) begin
      tickCnt <= divReg;
    end else begin
      tickCnt <= tickCnt - 1'b1;
    end
  end

  // SDA input synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= sdaIn;
      end
      assign sdaSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sdaIn};
      end
      assign sdaSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // Operand and shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      ackLvl  <= 1'b1;
    end else begin
      if (st.load) begin
        txShift <= cmdData;
        ackLvl  <= cmdAckLevel;
      end else if (st.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (st.captureRx) rxShift <= {rxShift[BYTE_W-2:0], sdaSync};
    end
  end

  // Results, held until replaced
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      ackBit <= 1'b0;
    end else begin
      if (st.commitRx)   rxData <= rxShift;
      if (st.captureAck) ackBit <= sdaSync;
    end
  end

  // Open-drain line enables: 1 pulls the line low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      if (st.sclLow)       sclOe <= 1'b1;
      else if (st.sclHigh) sclOe <= 1'b0;
      if (st.sdaLow)       sdaOe <= 1'b1;
      else if (st.sdaHigh) sdaOe <= 1'b0;
      else if (st.sdaTx)   sdaOe <= ~txShift[BYTE_W-1];
      else if (st.sdaAck)  sdaOe <= ~ackLvl;
    end
  end

endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
#(
  parameter int PULSES = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       tick,
  output strobe_t    st,
  output logic       cmdReady,
  output logic       done,
  output cmd_e       curCmd
);

  localparam int PC_W  = $clog2(PULSES + 1);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(BYTE_W - 1);
  localparam logic [PC_W-1:0]  LAST_PULSE = PC_W'(PULSES - 1);

  state_e            state, stateN;
  logic              half, halfN;
  logic [BIT_W-1:0]  bitIdx, bitIdxN;
  logic [PC_W-1:0]   pulseCnt, pulseCntN;
  cmd_e              cmdN;
  logic              doneN;
  logic              isLong, advance, isRead, cmdOk;

  assign isLong   = (state == ST_RLOW) || (state == ST_RHIGH) || (state == ST_BHIGH);
  assign advance  = tick && (!isLong || half);
  assign isRead   = (curCmd == CMD_READ);
  assign cmdOk    = (cmdCode <= 3'd4);
  assign cmdReady = (state == ST_IDLE);

  always_comb begin
    stateN    = state;
    halfN     = half;
    bitIdxN   = bitIdx;
    pulseCntN = pulseCnt;
    cmdN      = curCmd;
    doneN     = 1'b0;
    st        = '0;
    if (tick && isLong && !half) halfN = 1'b1;
    if (advance) halfN = 1'b0;
    if (state == ST_IDLE) begin
      if (cmdValid && cmdOk) begin
        st.load   = 1'b1;
        cmdN      = cmd_e'(cmdCode);
        bitIdxN   = '0;
        pulseCntN = '0;
        halfN     = 1'b0;
        case (cmd_e'(cmdCode))
          CMD_RECOVER: begin st.sclHigh = 1'b1; st.sdaHigh = 1'b1; stateN = ST_RINIT; end
          CMD_START:   begin st.sdaHigh = 1'b1; stateN = ST_SA; end
          CMD_STOP:    begin st.sclLow = 1'b1; stateN = ST_PA; end
          CMD_WRITE:   begin st.sclLow = 1'b1; stateN = ST_BLOW; end
          default:     begin st.sclLow = 1'b1; st.sdaHigh = 1'b1; stateN = ST_DLOW; end
        endcase
      end
    end else if (advance) begin
      case (state)
        ST_RINIT: begin st.sclLow = 1'b1; stateN = ST_RLOW; end
        ST_RLOW:  begin st.sclHigh = 1'b1; stateN = ST_RHIGH; end
        ST_RHIGH: begin
          st.sclLow = 1'b1;
          if (pulseCnt == LAST_PULSE) begin
            pulseCntN = '0;
            stateN    = ST_PA;
          end else begin
            pulseCntN = pulseCnt + 1'b1;
            stateN    = ST_RLOW;
          end
        end
        ST_SA: begin st.sclHigh = 1'b1; stateN = ST_SB; end
        ST_SB: begin st.sdaLow = 1'b1; stateN = ST_SC; end
        ST_PA: begin st.sdaLow = 1'b1; stateN = ST_PB; end
        ST_PB: begin st.sclHigh = 1'b1; stateN = ST_PC; end
        ST_PC: begin st.sdaHigh = 1'b1; stateN = ST_PD; end
        ST_SC, ST_PD: begin doneN = 1'b1; stateN = ST_IDLE; end
        ST_BLOW: begin
          if (bitIdx == ACK_IDX) begin
            if (isRead) st.sdaAck = 1'b1;
            else        st.sdaHigh = 1'b1;
          end else begin
            st.sdaTx = 1'b1;
          end
          stateN = ST_BSET;
        end
        ST_BSET: begin st.sclHigh = 1'b1; stateN = ST_BHIGH; end
        ST_BHIGH: begin
          st.sclLow = 1'b1;
          if (bitIdx == ACK_IDX) begin
            st.captureAck = !isRead;
            stateN = ST_ELOW;
          end else begin
            st.shiftTx = 1'b1;
            bitIdxN    = bitIdx + 1'b1;
            stateN     = ST_BLOW;
          end
        end
        ST_DLOW:  begin st.sclHigh = 1'b1; stateN = ST_DHIGH; end
        ST_DHIGH: begin st.captureRx = 1'b1; stateN = ST_DHOLD; end
        ST_DHOLD: begin
          st.sclLow = 1'b1;
          if (bitIdx == LAST_IDX) begin
            bitIdxN = ACK_IDX;
            stateN  = ST_BLOW;
          end else begin
            bitIdxN = bitIdx + 1'b1;
            stateN  = ST_DLOW;
          end
        end
        ST_ELOW: begin
          st.commitRx = isRead;
          doneN  = 1'b1;
          stateN = ST_IDLE;
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      half     <= 1'b0;
      bitIdx   <= '0;
      pulseCnt <= '0;
      curCmd   <= CMD_RECOVER;
      done     <= 1'b0;
    end else begin
      state    <= stateN;
      half     <= halfN;
      bitIdx   <= bitIdxN;
      pulseCnt <= pulseCntN;
      curCmd   <= cmdN;
      done     <= doneN;
    end
  end

  // R3: completion strobe never stretches
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: completion is reported only once the sequencer is back at idle
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int DIV_W          = 16,
  parameter int SYNC_STAGES    = 2,
  parameter int RECOVER_PULSES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdCode,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic              cmdAckLevel,
  input  logic [DIV_W-1:0]  divider,
  input  logic              sdaIn,
  output logic              cmdReady,
  output logic              done,
  output logic [BYTE_W-1:0] rxData,
  output logic              ackBit,
  output logic              sclOe,
  output logic              sdaOe
);

  strobe_t st;
  logic    tick;
  cmd_e    curCmd;

  i2c_bit_ctrl #(.PULSES(RECOVER_PULSES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .tick     (tick),
    .st       (st),
    .cmdReady (cmdReady),
    .done     (done),
    .curCmd   (curCmd)
  );

  i2c_bit_dp #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .cmdData     (cmdData),
    .cmdAckLevel (cmdAckLevel),
    .divider     (divider),
    .sdaIn       (sdaIn),
    .tick        (tick),
    .sclOe       (sclOe),
    .sdaOe       (sdaOe),
    .rxData      (rxData),
    .ackBit      (ackBit)
  );

  // R6: during byte transfers SDA holds still while SCL stays released
  assert_sda_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && (curCmd == CMD_WRITE || curCmd == CMD_READ) && !sclOe && !$past(sclOe))
      |-> $stable(sdaOe));

  // R10: idle engine keeps both lines where the last command left them
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !(cmdValid && cmdCode <= 3'd4)) |=> ($stable(sclOe) && $stable(sdaOe)));

  // R8: received byte only moves at the completion of a read
  assert_rx_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> (done && curCmd == CMD_READ));

  // R7: acknowledge result only moves during a write
  assert_ack_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ackBit) |-> (curCmd == CMD_WRITE));

endmodule

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;

  localparam int UN_START = 3, UN_STOP = 4, UN_WRITE = 37, UN_READ = 29, UN_RECOVER = 41;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdCode = 3'd0;
  logic [7:0]  cmdData = 8'd0;
  logic        cmdAckLevel = 1'b0;
  logic [15:0] divider = 16'd3;
  logic        sdaIn;
  logic        cmdReady, done, ackBit, sclOe, sdaOe;
  logic [7:0]  rxData;

  // slave model state
  logic        slaveLow = 1'b0;
  logic        sclPrev = 1'b1, sdaPrev = 1'b1;
  int          armSeq = 0, seenArm = 0, armMode = 0;
  logic [7:0]  armTx = 8'd0;
  logic        armAck = 1'b0;
  int          mode = 0, bitCount = 0, starts = 0, stops = 0, rises = 0;
  logic [7:0]  slvRx = 8'd0;
  logic        masterAck = 1'b1;

  int testCount = 0, failCount = 0;
  int seedDummy;

  always #2 clk = ~clk;

  assign sdaIn = !sdaOe && !slaveLow;

  i2c_bit_engine uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .cmdAckLevel(cmdAckLevel), .divider(divider),
    .sdaIn(sdaIn), .cmdReady(cmdReady), .done(done), .rxData(rxData),
    .ackBit(ackBit), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  // Slave on the wired-AND bus: mode 1 receives a byte, mode 2 sends one
  always @(negedge clk) begin
    logic sclNow, sdaNow;
    sclNow = !sclOe;
    sdaNow = sdaIn;
    if (armSeq != seenArm) begin
      seenArm = armSeq; mode = armMode; bitCount = 0; slvRx = 8'd0;
      masterAck = 1'b1; starts = 0; stops = 0; rises = 0;
      slaveLow = (armMode == 2) ? !armTx[7] : 1'b0;
    end else begin
      if (sclNow && sclPrev && sdaPrev && !sdaNow) starts++;
      if (sclNow && sclPrev && !sdaPrev && sdaNow) stops++;
      if (sclNow && !sclPrev) begin
        rises++;
        if (mode == 1 && bitCount < 8) slvRx = {slvRx[6:0], sdaNow};
        if (mode == 2 && bitCount == 8) masterAck = sdaNow;
        bitCount++;
      end
      if (!sclNow && sclPrev) begin
        if (mode == 1) begin
          if (bitCount == 8) slaveLow = !armAck;
          else if (bitCount == 9) slaveLow = 1'b0;
        end
        if (mode == 2) begin
          if (bitCount < 8) slaveLow = !armTx[7-bitCount];
          else slaveLow = 1'b0;
        end
      end
    end
    sclPrev = sclNow;
    sdaPrev = !sdaOe && !slaveLow;
  end

  function automatic int expLat(input int units, input int div);
    return units * (div + 1) + 1;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic arm(input int m, input logic [7:0] tx, input logic a);
    @(posedge clk);
    armMode = m; armTx = tx; armAck = a; armSeq++;
    @(negedge clk);
  endtask

  // Called at a negedge with the engine idle; returns at the negedge showing done
  task automatic runCmd(input logic [2:0] code, input logic [7:0] data, input logic ackLvl,
                        input int div, input int intrudeAt, output int lat);
    cmdCode = code; cmdData = data; cmdAckLevel = ackLvl; divider = 16'(div);
    cmdValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 1;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (intrudeAt != 0 && lat == intrudeAt) begin
        check("R2", "ready while busy", cmdReady, 0);
        cmdCode = 3'd2; cmdValid = 1'b1;
      end else begin
        cmdValid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++; testCount++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int lat, div;
    logic [7:0] byteV;
    logic bitV;
    seedDummy = $urandom(32'd91357);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "sclOe", sclOe, 0);
    check("R1", "sdaOe", sdaOe, 0);
    check("R1", "cmdReady", cmdReady, 1);
    check("R1", "done", done, 0);
    check("R1", "rxData", rxData, 0);
    check("R1", "ackBit", ackBit, 0);

    // R11 recovery from an idle bus
    arm(0, 8'h00, 1'b0);
    runCmd(3'd0, 8'h00, 1'b0, 3, 0, lat);
    check("R3", "recover latency", lat, expLat(UN_RECOVER, 3));
    check("R11", "scl rises", rises, 10);
    check("R11", "stop count", stops, 1);
    check("R11", "start count", starts, 0);
    @(negedge clk);
    check("R3", "done one cycle", done, 0);

    // R4 START
    arm(0, 8'h00, 1'b0);
    runCmd(3'd1, 8'h00, 1'b0, 4, 0, lat);
    check("R3", "start latency", lat, expLat(UN_START, 4));
    check("R4", "start count", starts, 1);
    check("R4", "scl released", sclOe, 0);
    check("R4", "sda low", sdaOe, 1);

    // R6/R7 write acknowledged
    arm(1, 8'h00, 1'b0);
    runCmd(3'd3, 8'hA5, 1'b0, 4, 0, lat);
    check("R3", "write latency", lat, expLat(UN_WRITE, 4));
    check("R6", "slave byte", slvRx, 8'hA5);
    check("R7", "ack sampled", ackBit, 0);
    check("R7", "rxData untouched", rxData, 0);
    check("R10", "scl low after write", sclOe, 1);
    check("R7", "sda released", sdaOe, 0);

    // R10 idle hold
    repeat (20) @(negedge clk);
    check("R10", "scl held", sclOe, 1);
    check("R10", "sda held", sdaOe, 0);

    // R7 write not acknowledged
    arm(1, 8'h00, 1'b1);
    runCmd(3'd3, 8'h3C, 1'b0, 5, 0, lat);
    check("R6", "slave byte", slvRx, 8'h3C);
    check("R7", "nack sampled", ackBit, 1);

    // R2 illegal code ignored
    cmdCode = 3'd6; cmdValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2", "ready with code 6", cmdReady, 1);
      check("R2", "no done with code 6", done, 0);
    end
    cmdValid = 1'b0;
    check("R2", "scl after code 6", sclOe, 1);

    // R8/R9 read with ACK
    arm(2, 8'h96, 1'b0);
    runCmd(3'd4, 8'h00, 1'b0, 4, 0, lat);
    check("R3", "read latency", lat, expLat(UN_READ, 4));
    check("R8", "rxData", rxData, 8'h96);
    check("R9", "master ack", masterAck, 0);
    check("R8", "ackBit untouched", ackBit, 1);
    check("R10", "scl low after read", sclOe, 1);

    // R2 request while busy ignored
    arm(1, 8'h00, 1'b0);
    runCmd(3'd3, 8'h5A, 1'b0, 4, 6, lat);
    check("R2", "busy write latency", lat, expLat(UN_WRITE, 4));
    check("R2", "busy write byte", slvRx, 8'h5A);
    check("R2", "no stop from ignored request", stops, 0);
    @(negedge clk);
    check("R2", "no second done", done, 0);

    // R9 read with NACK
    arm(2, 8'h0F, 1'b0);
    runCmd(3'd4, 8'h00, 1'b1, 3, 0, lat);
    check("R8", "rxData", rxData, 8'h0F);
    check("R9", "master nack", masterAck, 1);

    // R5 STOP
    arm(0, 8'h00, 1'b0);
    runCmd(3'd2, 8'h00, 1'b0, 4, 0, lat);
    check("R3", "stop latency", lat, expLat(UN_STOP, 4));
    check("R5", "stop count", stops, 1);
    check("R5", "start count", starts, 0);
    check("R5", "scl released", sclOe, 0);
    check("R5", "sda released", sdaOe, 0);

    // Random transactions
    for (int i = 0; i < 20; i++) begin
      div = 3 + int'($urandom_range(0, 5));
      arm(0, 8'h00, 1'b0);
      runCmd(3'd1, 8'h00, 1'b0, div, 0, lat);
      check("R4", "rand start", starts, 1);
      byteV = 8'($urandom); bitV = 1'($urandom);
      arm(1, 8'h00, bitV);
      runCmd(3'd3, byteV, 1'b0, div, 0, lat);
      check("R6", "rand write byte", slvRx, byteV);
      check("R7", "rand write ack", ackBit, bitV);
      check("R3", "rand write latency", lat, expLat(UN_WRITE, div));
      byteV = 8'($urandom); bitV = 1'($urandom);
      arm(2, byteV, 1'b0);
      runCmd(3'd4, 8'h00, bitV, div, 0, lat);
      check("R8", "rand read byte", rxData, byteV);
      check("R9", "rand read ack", masterAck, bitV);
      check("R3", "rand read latency", lat, expLat(UN_READ, div));
      arm(0, 8'h00, 1'b0);
      runCmd(3'd2, 8'h00, 1'b0, div, 0, lat);
      check("R5", "rand stop", stops, 1);
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule